// File: doc/BRIEF.md
# I2C GPIO Expander Slave

This block is an I2C slave that fronts an 8-bit general-purpose I/O port. A system clock oversamples SCL and SDA, so all bus events are seen as synchronous edges. When its own address is decoded, the block takes a command byte. The command byte selects one of four byte-wide registers: sampled pin levels, output latch, read polarity mask and pin direction. The master can then write any number of bytes into the selected register, or read it back any number of times.

The port side has one output value and one per-pin output enable, and it reads the raw pin levels. SDA is shown as a single pull-low request (`sdaDriveLow`), and the pad combines that request with the bus wire. The selection made by the last command byte stays in force for later transactions and repeated Starts. An active-low reset returns every register and the bus sequencer to the power-up state.

Top module: `pexp_top`

## Requirements
- R1: The block answers (pulls SDA low in the ninth clock) only to an address byte whose upper seven bits are binary 0011 followed by `addrPins[2:0]`; bit 0 of the address byte is the direction, 1 meaning read. A non-matching address gets no acknowledge, and the block ignores every byte that follows until the next Start.
- R2: In a write transaction, the byte after the address is a command byte and is acknowledged. Its two low bits select the register: 0 pin levels, 1 output latch, 2 polarity mask, 3 direction.
- R3: Every data byte written after the command byte is acknowledged and lands in the selected register, the last one winning. Data written while selection 0 is active changes nothing.
- R4: The selection persists across repeated Starts, Stops and new transactions until another command byte is written, so reads keep returning the selected register.
- R5: While `rstN` is low, and after it rises, the output latch is 0x00, the polarity mask is 0xF0, the direction register is 0xFF and the selection is 0. So `portOut` is 0x00 and `portOe` is 0x00.
- R6: `portOe[i]` is 1 exactly when direction bit i is 0, and `portOut` always shows the output latch.
- R7: A read of selection 0 returns `pinIn` XOR the polarity mask, whatever the pin directions are. The pins are captured at the start of each transmitted byte, and changes within that byte are not seen.
- R8: A read of selection 1 returns the latched output value, not the pin levels.
- R9: A written output or direction byte is visible on `portOut`/`portOe` before SCL rises for that byte's acknowledge clock.
- R10: After the master NACKs a read byte, the block releases SDA and keeps it released through further SCL clocks until the next Start.
- R11: The block changes `sdaDriveLow` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level (wired value) |
| sdaDriveLow | output | 1 | 1 requests the pad to pull SDA low |
| addrPins | input | 3 | Strapped low address bits |
| pinIn | input | 8 | Pin levels seen at the port |
| portOut | output | 8 | Output latch value for the pin drivers |
| portOe | output | 8 | Per-pin driver enable, 1 = driving |

## Verification
The bench uses the default two-stage synchronizer and the 0xF0 polarity reset value, with the address straps tied to 101. The bus half-period is ten system clocks. That is long enough for the synchronizer latency to settle inside each SCL phase, and short enough that acknowledge-time updates, byte-start input capture and SDA stability around SCL high can all be observed clock by clock. The default polarity value makes the first input read come back with its upper nibble inverted, without any setup write. That exercises the inversion path straight out of reset.

// File: rtl/pexp_pkg.sv
package pexp_pkg;
  localparam int BYTE_W    = 8;
  localparam int DEV_ID_W  = 4;
  localparam int ADDR_PINS = BYTE_W - 1 - DEV_ID_W;
  localparam logic [DEV_ID_W-1:0] DEV_ID = 4'b0011;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK,
    ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } busState_t;

  typedef struct packed {
    logic              cmdWr;
    logic              dataWr;
    logic              rdLoad;
    logic [BYTE_W-1:0] wrByte;
  } regStrobe_t;
endpackage

// File: rtl/pexp_regs.sv
module pexp_regs
  import pexp_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OUT_RESET = '0,
  parameter logic [BYTE_W-1:0] POL_RESET = 8'hF0,
  parameter logic [BYTE_W-1:0] DIR_RESET = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [BYTE_W-1:0] pinIn,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] portOut,
  output logic [BYTE_W-1:0] portOe
);
  logic [BYTE_W-1:0] outReg, polReg, dirReg;
  logic [1:0]        cmdPtr;
  logic [BYTE_W-1:0] selVal;

  always_comb begin
    unique case (cmdPtr)
      2'd0: selVal = pinIn ^ polReg;
      2'd1: selVal = outReg;
      2'd2: selVal = polReg;
      default: selVal = dirReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= OUT_RESET;
      polReg <= POL_RESET;
      dirReg <= DIR_RESET;
      cmdPtr <= '0;
      rdData <= '0;
    end else begin
      if (strobe.cmdWr) cmdPtr <= strobe.wrByte[1:0];
      if (strobe.dataWr) begin
        case (cmdPtr)
          2'd1: outReg <= strobe.wrByte;
          2'd2: polReg <= strobe.wrByte;
          2'd3: dirReg <= strobe.wrByte;
          default: ;
        endcase
      end
      if (strobe.rdLoad) rdData <= selVal;
    end
  end

  assign portOut = outReg;
  assign portOe  = ~dirReg;

  // R3: register contents move only on a data write strobe
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataWr |=> ($stable(outReg) && $stable(polReg) && $stable(dirReg)));
  // R3: writes under selection 0 leave every register alone
  a_r3_input_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataWr && cmdPtr == 2'd0) |=> ($stable(outReg) && $stable(polReg) && $stable(dirReg)));
endmodule

// File: rtl/pexp_ctrl.sv
module pexp_ctrl
  import pexp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [ADDR_PINS-1:0] addrPins,
  input  logic [BYTE_W-1:0]    rdData,
  output regStrobe_t           strobe,
  output logic                 sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclChain, sdaChain;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startCond, stopCond;

  busState_t         state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [IDX_W-1:0]  txIdx;
  logic ackLow, txActive, rwBit, mAck;
  logic byteDone, addrMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclP     <= 1'b1;
      sdaP     <= 1'b1;
    end else begin
      sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
      sclP     <= sclS;
      sdaP     <= sdaS;
    end
  end

  assign sclS      = sclChain[SYNC_STAGES-1];
  assign sdaS      = sdaChain[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclP;
  assign sclFall   = ~sclS & sclP;
  assign startCond = sclS & sclP & sdaP & ~sdaS;
  assign stopCond  = sclS & sclP & ~sdaP & sdaS;
  assign byteDone  = (bitCnt == CNT_W'(BYTE_W));
  assign addrMatch = (shiftReg[BYTE_W-1:1] == {DEV_ID, addrPins});

  always_comb begin
    strobe        = '0;
    strobe.wrByte = shiftReg;
    if (sclFall && byteDone) begin
      strobe.cmdWr  = (state == ST_CMD);
      strobe.dataWr = (state == ST_WDATA);
    end
    if (sclFall && ((state == ST_AACK && rwBit) || (state == ST_RACK && mAck)))
      strobe.rdLoad = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      txIdx    <= '0;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
      rwBit    <= 1'b0;
      mAck     <= 1'b0;
    end else if (startCond || stopCond) begin
      state    <= startCond ? ST_ADDR : ST_IDLE;
      bitCnt   <= '0;
      ackLow   <= 1'b0;
      txActive <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (sclRise) begin
            shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
            bitCnt   <= bitCnt + CNT_W'(1);
          end else if (sclFall && byteDone) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (addrMatch) begin
                ackLow <= 1'b1;
                rwBit  <= shiftReg[0];
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              ackLow <= 1'b1;
              state  <= (state == ST_CMD) ? ST_CACK : ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (sclFall) begin
            ackLow <= 1'b0;
            if (rwBit) begin
              state    <= ST_RDATA;
              txActive <= 1'b1;
              txIdx    <= '0;
            end else begin
              state <= ST_CMD;
            end
          end
        end
        ST_CACK, ST_WACK: begin
          if (sclFall) begin
            ackLow <= 1'b0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + CNT_W'(1);
          end else if (sclFall) begin
            if (byteDone) begin
              txActive <= 1'b0;
              bitCnt   <= '0;
              state    <= ST_RACK;
            end else begin
              txIdx <= bitCnt[IDX_W-1:0];
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mAck <= ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              state    <= ST_RDATA;
              txActive <= 1'b1;
              txIdx    <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = ackLow | (txActive & ~rdData[~txIdx]);

  // R11: SDA request never moves while SCL has been high for two samples
  a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclP && !startCond && !stopCond) |-> $stable(sdaDriveLow));
  // R1: a foreign address drops the sequencer to idle without an acknowledge
  a_r1_foreign_addr_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && byteDone && !addrMatch) |=> (state == ST_IDLE && !sdaDriveLow));
  // R10: a NACK from the master leaves SDA released
  a_r10_nack_releases: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclFall && !mAck) |=> !sdaDriveLow);
  // R3: at most one register strobe per cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cmdWr, strobe.dataWr, strobe.rdLoad}));
endmodule

// File: rtl/pexp_top.sv
module pexp_top
  import pexp_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] POL_RESET   = 8'hF0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaDriveLow,
  input  logic [ADDR_PINS-1:0] addrPins,
  input  logic [BYTE_W-1:0]    pinIn,
  output logic [BYTE_W-1:0]    portOut,
  output logic [BYTE_W-1:0]    portOe
);
  regStrobe_t        strobe;
  logic [BYTE_W-1:0] rdData;

  pexp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrPins(addrPins), .rdData(rdData), .strobe(strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  pexp_regs #(.POL_RESET(POL_RESET)) regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pinIn(pinIn),
    .rdData(rdData), .portOut(portOut), .portOe(portOe)
  );
endmodule

// File: tb/pexp_top_test.sv
module pexp_top_test;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] devPins = 3'b101;
  logic [7:0] pinIn = 8'h00;
  logic sdaDriveLow;
  logic [7:0] portOut, portOe;
  wire sdaLine = sdaM & ~sdaDriveLow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit cmpEn = 1'b1;
  logic [7:0] expOut = 8'h00, expPol = 8'hF0, expDir = 8'hFF;
  logic [1:0] expPtr = 2'd0;
  logic prevScl = 1'b1, prevDrv = 1'b0;

  always #4 clk = ~clk;

  pexp_top uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .addrPins(devPins), .pinIn(pinIn),
    .portOut(portOut), .portOe(portOe)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Per-clock reference comparison (R5, R6, R11)
  always @(negedge clk) begin
    if (cmpEn) begin
      chk(portOut == expOut, "R6 portOut", portOut, expOut);
      chk(portOe == ~expDir, "R6 portOe", portOe, ~expDir);
    end
    if (rstN && scl && prevScl)
      chk(sdaDriveLow == prevDrv, "R11 sda moved with scl high", {7'd0, sdaDriveLow}, {7'd0, prevDrv});
    prevScl = scl;
    prevDrv = sdaDriveLow;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  function automatic logic [7:0] expRead();
    case (expPtr)
      2'd0: return pinIn ^ expPol;
      2'd1: return expOut;
      2'd2: return expPol;
      default: return expDir;
    endcase
  endfunction

  task automatic hclk();
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1; hclk(); scl = 1; hclk(); sdaM = 0; hclk(); scl = 0; hclk();
  endtask

  task automatic busStop();
    sdaM = 0; hclk(); scl = 1; hclk(); sdaM = 1; hclk();
  endtask

  // kind: 0 address, 1 command, 2 data
  task automatic sendByte(input logic [7:0] b, input int kind, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; hclk(); scl = 1; hclk();
      if (i == 0) cmpEn = 0;
      scl = 0;
    end
    sdaM = 1; hclk(); scl = 1; hclk();
    ack = ~sdaLine;
    if (ack && kind == 1) expPtr = b[1:0];
    if (ack && kind == 2) begin
      case (expPtr)
        2'd1: expOut = b;
        2'd2: expPol = b;
        2'd3: expDir = b;
        default: ;
      endcase
      chk(portOut == expOut && portOe == ~expDir, "R9 update by ack", portOut, expOut);
    end
    cmpEn = 1;
    scl = 0; hclk();
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      hclk(); scl = 1; hclk(); b[i] = sdaLine; scl = 0;
    end
    sdaM = ~ackIt; hclk(); scl = 1; hclk(); scl = 0; sdaM = 1; hclk();
  endtask

  task automatic addrByte(input bit rd, output logic ack);
    sendByte({4'b0011, devPins, rd}, 0, ack);
  endtask

  task automatic writeReg(input logic [1:0] ptr, input logic [7:0] d);
    logic a;
    busStart(); addrByte(0, a); chk(a, "R1 addr ack", {7'd0, a}, 8'd1);
    sendByte({6'd0, ptr}, 1, a); chk(a, "R2 cmd ack", {7'd0, a}, 8'd1);
    sendByte(d, 2, a); chk(a, "R3 data ack", {7'd0, a}, 8'd1);
    busStop();
  endtask

  task automatic readSel(input logic [1:0] ptr, input string req);
    logic a; logic [7:0] v;
    busStart(); addrByte(0, a); sendByte({6'd0, ptr}, 1, a);
    busStart(); addrByte(1, a); chk(a, "R1 read addr ack", {7'd0, a}, 8'd1);
    recvByte(0, v); chk(v == expRead(), req, v, expRead());
    busStop();
  endtask

  initial begin
    logic a; logic [7:0] v;
    #3;
    repeat (5) @(posedge clk); #1;
    chk(portOut == 8'h00 && portOe == 8'h00, "R5 outputs in reset", portOe, 8'h00);
    rstN = 1; hclk();

    // R5 / R4: polarity default through a repeated Start
    readSel(2'd2, "R5 polarity reset 0xF0");
    readSel(2'd3, "R5 direction reset 0xFF");

    // R6: low nibble inputs, high nibble outputs
    writeReg(2'd3, 8'h0F);
    chk(portOe == 8'hF0, "R6 oe from direction", portOe, 8'hF0);

    // R3: multi-byte write, last byte wins
    busStart(); addrByte(0, a); sendByte(8'h01, 1, a);
    sendByte(8'hA5, 2, a); chk(a, "R3 first data ack", {7'd0, a}, 8'd1);
    sendByte(8'h3C, 2, a); chk(a, "R3 second data ack", {7'd0, a}, 8'd1);
    busStop();
    chk(portOut == 8'h3C, "R3 last byte wins", portOut, 8'h3C);

    // R8 / R4: fresh read transaction keeps selection 1, pins differ
    pinIn = 8'hC3;
    busStart(); addrByte(1, a);
    recvByte(1, v); chk(v == 8'h3C, "R8 latch not pin", v, 8'h3C);
    recvByte(0, v); chk(v == 8'h3C, "R4 selection persists", v, 8'h3C);
    busStop();

    // R7: inverted input, captured at byte start
    pinIn = 8'h5A;
    busStart(); addrByte(0, a); sendByte(8'h00, 1, a);
    busStart(); addrByte(1, a);
    recvByte(1, v); chk(v == 8'hAA, "R7 inverted input", v, 8'hAA);
    pinIn = 8'h01;
    recvByte(1, v); chk(v == 8'hAA, "R7 capture at byte start", v, 8'hAA);
    recvByte(0, v); chk(v == 8'hF1, "R7 next byte live pins", v, 8'hF1);
    busStop();

    // R7: polarity cleared
    writeReg(2'd2, 8'h00);
    pinIn = 8'h5A;
    readSel(2'd0, "R7 plain input");

    // R1: foreign address ignored
    busStart();
    sendByte({4'b0011, 3'b010, 1'b0}, 0, a); chk(!a, "R1 foreign no ack", {7'd0, a}, 8'd0);
    sendByte(8'h01, 0, a); chk(!a, "R1 ignored cmd", {7'd0, a}, 8'd0);
    sendByte(8'hFF, 0, a); chk(!a, "R1 ignored data", {7'd0, a}, 8'd0);
    busStop();
    busStart(); addrByte(1, a);
    recvByte(0, v); chk(v == 8'h5A, "R1 selection untouched", v, 8'h5A);
    busStop();

    // R3: write to selection 0 changes nothing
    busStart(); addrByte(0, a); sendByte(8'h00, 1, a);
    sendByte(8'hFF, 2, a); chk(a, "R3 input write acked", {7'd0, a}, 8'd1);
    busStop();
    readSel(2'd1, "R3 output after input write");
    readSel(2'd2, "R3 polarity after input write");

    // R10: NACK then extra clocks, SDA stays released
    busStart(); addrByte(1, a); recvByte(0, v);
    for (int k = 0; k < 9; k++) begin
      hclk(); scl = 1; hclk();
      chk(sdaLine == 1'b1, "R10 released after nack", {7'd0, sdaLine}, 8'd1);
      scl = 0;
    end
    hclk(); busStop();

    // R5: reset held low mid-operation
    writeReg(2'd1, 8'h77);
    rstN = 0; expOut = 8'h00; expPol = 8'hF0; expDir = 8'hFF; expPtr = 2'd0;
    hclk();
    chk(portOut == 8'h00 && portOe == 8'h00, "R5 reset held", portOut, 8'h00);
    rstN = 1; hclk();
    readSel(2'd3, "R5 direction after reset");
    readSel(2'd1, "R5 output after reset");

    summary();
  end
endmodule